// File: doc/BRIEF.md
# Write-Back Data Cache with SRAM Mode

This block sits between a 32-bit processor load/store port and an external burst memory bus. It holds 2 KB of data. In cache mode the storage is organised as 128 direct-mapped lines of four 32-bit words with a write-back policy. A miss fetches the whole line with a four-beat read burst. If the line being replaced holds modified data, that line first goes out as a four-beat write burst. The processor is stalled until the requested word is ready.

A plain configuration input, `cfg_sram_mode`, turns the same storage into 512 words of directly addressed on-chip SRAM. In that mode tags are not consulted, nothing is sent on the external bus and every access completes in fixed latency. Changing the mode invalidates every line and discards any modified data, so software must flush before switching.

The processor request is a valid/ready stream. The requester holds `cpu_req_*` stable while `cpu_req_valid` is high and `cpu_req_ready` is low. A transfer happens on a clock edge where both are high. The response is a one-cycle pulse on `cpu_rsp_valid`; it carries no ready and cannot be back-pressured. On the memory side the burst request is a valid/ready handshake. Write beats advance only on `mem_wvalid` && `mem_wready`. Read beats are taken on every cycle that `mem_rvalid` is high, because the cache always accepts them.

Top module: `dcache_wb`

## Requirements
- R1: Geometry: word offset is addr[3:2], line index is addr[10:4] (128 lines) and tag is addr[31:11]; two addresses with the same index and different tags evict each other.
- R2: A load that hits is answered with `cpu_rsp_valid` high exactly one cycle after acceptance, returns the last value stored to that address, and causes no memory request.
- R3: A store that hits updates only the cache, causes no memory request, and marks the line modified.
- R4: On a store, bit i of `cpu_req_be` enables byte lane i (data bits 8i+7..8i); other lanes keep their previous value.
- R5: A miss to an invalid or unmodified line issues exactly one read burst request with `mem_req_we`=0 at the line base address (addr with bits [3:0] zero). Four beats fill words 0..3 in ascending order, after which the access completes.
- R6: A miss to a modified line first issues a write burst request (`mem_req_we`=1) at the victim line base and sends its four current words in ascending order. No read burst request appears until all four write beats have completed.
- R7: From the acceptance of a missing request until its response, `cpu_req_ready` stays low and no response is given in the cycle after acceptance.
- R8: With `cfg_sram_mode`=1, addr[10:2] selects one of 512 words and higher bits are ignored. Every access responds one cycle after acceptance, and no memory request or write beat is ever issued.
- R9: A change of `cfg_sram_mode` invalidates all lines and drops modified data. After returning to cache mode, an access to a previously modified line causes only a read burst and returns the external memory's older value.
- R10: `mem_req_valid`, `mem_req_we` and `mem_req_addr` stay stable until `mem_req_ready` is seen.
- R11: After reset `cpu_req_ready` is high, `cpu_rsp_valid` and `mem_req_valid` are low, and all lines are invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_sram_mode | input | 1 | 1 = plain SRAM, 0 = write-back cache |
| cpu_req_valid | input | 1 | Processor request valid |
| cpu_req_ready | output | 1 | Block can accept a request |
| cpu_req_we | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | 32 | Byte address |
| cpu_req_be | input | 4 | Store byte enables |
| cpu_req_wdata | input | 32 | Store data |
| cpu_rsp_valid | output | 1 | One-cycle completion pulse |
| cpu_rsp_rdata | output | 32 | Load data |
| mem_req_valid | output | 1 | Burst request valid |
| mem_req_ready | input | 1 | Burst request accepted |
| mem_req_we | output | 1 | 1 = write burst, 0 = read burst |
| mem_req_addr | output | 32 | Line base address of the burst |
| mem_wvalid | output | 1 | Write beat valid |
| mem_wready | input | 1 | Write beat accepted |
| mem_wdata | output | 32 | Write beat data |
| mem_rvalid | input | 1 | Read beat valid |
| mem_rdata | input | 32 | Read beat data |

## Verification
The assertions check, on every cycle, the timing rules: hit and SRAM responses one cycle after acceptance, no response the cycle after a miss, a stable burst request under back-pressure, no bus traffic in SRAM mode, no read burst while the victim is still modified, and no valid line after a mode change. Only the bench's scenarios can show that the data is right. That covers the values returned after byte-masked stores, the contents and order of write-back beats, the addresses of the bursts, the aliasing of high address bits in SRAM mode, and the older memory value that reappears after dirty data is discarded by a mode switch.

// File: rtl/dc_pkg.sv
package dc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WB_REQ,
    ST_WB_DATA,
    ST_RF_REQ,
    ST_RF_DATA,
    ST_REPLAY
  } dc_state_e;
endpackage

// File: rtl/dc_tag_store.sv
module dc_tag_store #(
  parameter int IDX_W = 7,
  parameter int TAG_W = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  output logic [TAG_W-1:0] lk_tag,
  output logic             lk_valid,
  output logic             lk_dirty,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             mark_en,
  input  logic [IDX_W-1:0] mark_idx,
  input  logic             clean_en,
  input  logic [IDX_W-1:0] clean_idx,
  input  logic             inval_all,
  output logic             any_valid
);
  localparam int LINES = 1 << IDX_W;

  logic [TAG_W-1:0] tag_mem [LINES];
  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;

  always_ff @(posedge clk) begin
    if (fill_en) tag_mem[fill_idx] <= fill_tag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (inval_all) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      if (fill_en) begin
        valid_q[fill_idx] <= 1'b1;
        dirty_q[fill_idx] <= 1'b0;
      end
      if (mark_en)  dirty_q[mark_idx]  <= 1'b1;
      if (clean_en) dirty_q[clean_idx] <= 1'b0;
    end
  end

  assign lk_tag    = tag_mem[lk_idx];
  assign lk_valid  = valid_q[lk_idx];
  assign lk_dirty  = dirty_q[lk_idx];
  assign any_valid = |valid_q;
endmodule

// File: rtl/dc_data_store.sv
module dc_data_store #(
  parameter int WADDR_W = 9,
  parameter int DATA_W  = 32
) (
  input  logic                  clk,
  input  logic                  we,
  input  logic [WADDR_W-1:0]    waddr,
  input  logic [DATA_W/8-1:0]   wbe,
  input  logic [DATA_W-1:0]     wdata,
  input  logic [WADDR_W-1:0]    raddr_a,
  output logic [DATA_W-1:0]     rdata_a,
  input  logic [WADDR_W-1:0]    raddr_b,
  output logic [DATA_W-1:0]     rdata_b
);
  localparam int NB    = DATA_W / 8;
  localparam int WORDS = 1 << WADDR_W;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic [7:0] lane [WORDS];
    always_ff @(posedge clk) begin
      if (we && wbe[b]) lane[waddr] <= wdata[8*b +: 8];
    end
    assign rdata_a[8*b +: 8] = lane[raddr_a];
    assign rdata_b[8*b +: 8] = lane[raddr_b];
  end
endmodule

// File: rtl/dc_ctrl.sv
module dc_ctrl
  import dc_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int IDX_W    = 7,
  parameter int OFF_W    = 2,
  parameter int BYTE_OFF = 2,
  parameter int TAG_W    = 21,
  parameter int WADDR_W  = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_sram_mode,
  input  logic                cpu_req_valid,
  output logic                cpu_req_ready,
  input  logic                cpu_req_we,
  input  logic [ADDR_W-1:0]   cpu_req_addr,
  input  logic [DATA_W/8-1:0] cpu_req_be,
  input  logic [DATA_W-1:0]   cpu_req_wdata,
  output logic                cpu_rsp_valid,
  output logic [DATA_W-1:0]   cpu_rsp_rdata,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic                mem_req_we,
  output logic [ADDR_W-1:0]   mem_req_addr,
  output logic                mem_wvalid,
  input  logic                mem_wready,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic                mem_rvalid,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic [IDX_W-1:0]    lk_idx,
  input  logic [TAG_W-1:0]    lk_tag,
  input  logic                lk_valid,
  input  logic                lk_dirty,
  output logic                fill_en,
  output logic [IDX_W-1:0]    fill_idx,
  output logic [TAG_W-1:0]    fill_tag,
  output logic                mark_en,
  output logic [IDX_W-1:0]    mark_idx,
  output logic                clean_en,
  output logic [IDX_W-1:0]    clean_idx,
  output logic                inval_all,
  input  logic                any_valid,
  output logic                dat_we,
  output logic [WADDR_W-1:0]  dat_waddr,
  output logic [DATA_W/8-1:0] dat_wbe,
  output logic [DATA_W-1:0]   dat_wdata,
  output logic [WADDR_W-1:0]  dat_raddr_a,
  input  logic [DATA_W-1:0]   dat_rdata_a,
  output logic [WADDR_W-1:0]  dat_raddr_b,
  input  logic [DATA_W-1:0]   dat_rdata_b
);
  localparam int NB = DATA_W / 8;
  localparam int LOW_W = OFF_W + BYTE_OFF;
  localparam logic [OFF_W-1:0] BEAT_LAST = {OFF_W{1'b1}};

  dc_state_e state_q, state_d;
  logic                mode_q;
  logic [OFF_W-1:0]    beat_q, beat_d;
  logic [ADDR_W-1:0]   rq_addr;
  logic                rq_we;
  logic [NB-1:0]       rq_be;
  logic [DATA_W-1:0]   rq_wdata;
  logic [TAG_W-1:0]    vtag_q;
  logic                rsp_valid_q;
  logic [DATA_W-1:0]   rsp_rdata_q;

  // request currently presented to the lookup and data path
  logic                in_replay;
  logic [ADDR_W-1:0]   cur_addr;
  logic                cur_we;
  logic [NB-1:0]       cur_be;
  logic [DATA_W-1:0]   cur_wdata;
  logic [IDX_W-1:0]    cur_idx, rq_idx;
  logic [OFF_W-1:0]    cur_off;
  logic [TAG_W-1:0]    cur_tag, rq_tag;
  logic                unused_low;

  logic mode_chg, accept, hit, access_fire, miss_fire, wbeat, rbeat;

  assign in_replay = (state_q == ST_REPLAY);
  assign cur_addr  = in_replay ? rq_addr  : cpu_req_addr;
  assign cur_we    = in_replay ? rq_we    : cpu_req_we;
  assign cur_be    = in_replay ? rq_be    : cpu_req_be;
  assign cur_wdata = in_replay ? rq_wdata : cpu_req_wdata;
  assign cur_off   = cur_addr[BYTE_OFF +: OFF_W];
  assign cur_idx   = cur_addr[LOW_W +: IDX_W];
  assign cur_tag   = cur_addr[ADDR_W-1 -: TAG_W];
  assign rq_idx    = rq_addr[LOW_W +: IDX_W];
  assign rq_tag    = rq_addr[ADDR_W-1 -: TAG_W];
  assign unused_low = ^{cur_addr[BYTE_OFF-1:0], rq_addr[LOW_W-1:0]};

  assign mode_chg      = (cfg_sram_mode != mode_q);
  assign cpu_req_ready = (state_q == ST_IDLE) && !mode_chg;
  assign accept        = cpu_req_valid && cpu_req_ready;
  assign lk_idx        = (state_q == ST_IDLE) ? cur_idx : rq_idx;
  assign hit           = lk_valid && (lk_tag == cur_tag);
  assign access_fire   = (accept && (mode_q || hit)) || in_replay;
  assign miss_fire     = accept && !mode_q && !hit;
  assign inval_all     = (state_q == ST_IDLE) && mode_chg;
  assign wbeat         = (state_q == ST_WB_DATA) && mem_wready;
  assign rbeat         = (state_q == ST_RF_DATA) && mem_rvalid;

  // data array: refill beats and processor accesses never overlap in time
  always_comb begin
    if (rbeat) begin
      dat_we    = 1'b1;
      dat_waddr = {rq_idx, beat_q};
      dat_wbe   = '1;
      dat_wdata = mem_rdata;
    end else begin
      dat_we    = access_fire && cur_we;
      dat_waddr = {cur_idx, cur_off};
      dat_wbe   = cur_be;
      dat_wdata = cur_wdata;
    end
  end
  assign dat_raddr_a = {cur_idx, cur_off};
  assign dat_raddr_b = {rq_idx, beat_q};

  // tag store updates
  assign fill_en   = rbeat && (beat_q == BEAT_LAST);
  assign fill_idx  = rq_idx;
  assign fill_tag  = rq_tag;
  assign mark_en   = access_fire && cur_we && !mode_q;
  assign mark_idx  = cur_idx;
  assign clean_en  = wbeat && (beat_q == BEAT_LAST);
  assign clean_idx = rq_idx;

  // bus outputs
  assign mem_wdata    = dat_rdata_b;
  assign mem_req_addr = (state_q == ST_WB_REQ) ? {vtag_q, rq_idx, {LOW_W{1'b0}}}
                                               : {rq_tag, rq_idx, {LOW_W{1'b0}}};

  always_comb begin
    state_d       = state_q;
    beat_d        = beat_q;
    mem_req_valid = 1'b0;
    mem_req_we    = 1'b0;
    mem_wvalid    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (miss_fire) begin
          beat_d  = '0;
          state_d = (lk_valid && lk_dirty) ? ST_WB_REQ : ST_RF_REQ;
        end
      end
      ST_WB_REQ: begin
        mem_req_valid = 1'b1;
        mem_req_we    = 1'b1;
        if (mem_req_ready) state_d = ST_WB_DATA;
      end
      ST_WB_DATA: begin
        mem_wvalid = 1'b1;
        if (mem_wready) begin
          beat_d = beat_q + 1'b1;
          if (beat_q == BEAT_LAST) state_d = ST_RF_REQ;
        end
      end
      ST_RF_REQ: begin
        mem_req_valid = 1'b1;
        if (mem_req_ready) begin
          beat_d  = '0;
          state_d = ST_RF_DATA;
        end
      end
      ST_RF_DATA: begin
        if (mem_rvalid) begin
          beat_d = beat_q + 1'b1;
          if (beat_q == BEAT_LAST) state_d = ST_REPLAY;
        end
      end
      ST_REPLAY: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      mode_q      <= 1'b0;
      beat_q      <= '0;
      rq_addr     <= '0;
      rq_we       <= 1'b0;
      rq_be       <= '0;
      rq_wdata    <= '0;
      vtag_q      <= '0;
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      state_q     <= state_d;
      beat_q      <= beat_d;
      rsp_valid_q <= access_fire;
      if (access_fire) rsp_rdata_q <= dat_rdata_a;
      if (inval_all)   mode_q <= cfg_sram_mode;
      if (miss_fire) begin
        rq_addr  <= cpu_req_addr;
        rq_we    <= cpu_req_we;
        rq_be    <= cpu_req_be;
        rq_wdata <= cpu_req_wdata;
        vtag_q   <= lk_tag;
      end
    end
  end

  assign cpu_rsp_valid = rsp_valid_q;
  assign cpu_rsp_rdata = rsp_rdata_q;

  AST_HIT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !mode_q && hit |=> cpu_rsp_valid); // R2
  AST_MISS_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    miss_fire |=> !cpu_rsp_valid && !cpu_req_ready); // R7
  AST_SRAM_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    accept && mode_q |=> cpu_rsp_valid); // R8
  AST_SRAM_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q |-> !mem_req_valid && !mem_wvalid); // R8
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we)); // R10
  AST_RF_AFTER_WB: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_we |-> !(lk_valid && lk_dirty)); // R6
  AST_MODE_INVAL: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != $past(mode_q)) |-> !any_valid); // R9
endmodule

// File: rtl/dcache_wb.sv
module dcache_wb #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int NUM_LINES  = 128
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_sram_mode,
  input  logic                cpu_req_valid,
  output logic                cpu_req_ready,
  input  logic                cpu_req_we,
  input  logic [ADDR_W-1:0]   cpu_req_addr,
  input  logic [DATA_W/8-1:0] cpu_req_be,
  input  logic [DATA_W-1:0]   cpu_req_wdata,
  output logic                cpu_rsp_valid,
  output logic [DATA_W-1:0]   cpu_rsp_rdata,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic                mem_req_we,
  output logic [ADDR_W-1:0]   mem_req_addr,
  output logic                mem_wvalid,
  input  logic                mem_wready,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic                mem_rvalid,
  input  logic [DATA_W-1:0]   mem_rdata
);
  localparam int IDX_W    = $clog2(NUM_LINES);
  localparam int OFF_W    = $clog2(LINE_WORDS);
  localparam int BYTE_OFF = $clog2(DATA_W / 8);
  localparam int TAG_W    = ADDR_W - IDX_W - OFF_W - BYTE_OFF;
  localparam int WADDR_W  = IDX_W + OFF_W;
  localparam int NB       = DATA_W / 8;

  logic [IDX_W-1:0]   lk_idx, fill_idx, mark_idx, clean_idx;
  logic [TAG_W-1:0]   lk_tag, fill_tag;
  logic               lk_valid, lk_dirty, fill_en, mark_en, clean_en, inval_all, any_valid;
  logic               dat_we;
  logic [WADDR_W-1:0] dat_waddr, dat_raddr_a, dat_raddr_b;
  logic [NB-1:0]      dat_wbe;
  logic [DATA_W-1:0]  dat_wdata, dat_rdata_a, dat_rdata_b;

  dc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .lk_idx(lk_idx), .lk_tag(lk_tag), .lk_valid(lk_valid), .lk_dirty(lk_dirty),
    .fill_en(fill_en), .fill_idx(fill_idx), .fill_tag(fill_tag),
    .mark_en(mark_en), .mark_idx(mark_idx),
    .clean_en(clean_en), .clean_idx(clean_idx),
    .inval_all(inval_all), .any_valid(any_valid)
  );

  dc_data_store #(.WADDR_W(WADDR_W), .DATA_W(DATA_W)) u_data (
    .clk(clk), .we(dat_we), .waddr(dat_waddr), .wbe(dat_wbe), .wdata(dat_wdata),
    .raddr_a(dat_raddr_a), .rdata_a(dat_rdata_a),
    .raddr_b(dat_raddr_b), .rdata_b(dat_rdata_b)
  );

  dc_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .OFF_W(OFF_W),
    .BYTE_OFF(BYTE_OFF), .TAG_W(TAG_W), .WADDR_W(WADDR_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_sram_mode(cfg_sram_mode),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_we(cpu_req_we), .cpu_req_addr(cpu_req_addr),
    .cpu_req_be(cpu_req_be), .cpu_req_wdata(cpu_req_wdata),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_rdata(cpu_rsp_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_wvalid(mem_wvalid), .mem_wready(mem_wready), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .lk_idx(lk_idx), .lk_tag(lk_tag), .lk_valid(lk_valid), .lk_dirty(lk_dirty),
    .fill_en(fill_en), .fill_idx(fill_idx), .fill_tag(fill_tag),
    .mark_en(mark_en), .mark_idx(mark_idx),
    .clean_en(clean_en), .clean_idx(clean_idx),
    .inval_all(inval_all), .any_valid(any_valid),
    .dat_we(dat_we), .dat_waddr(dat_waddr), .dat_wbe(dat_wbe), .dat_wdata(dat_wdata),
    .dat_raddr_a(dat_raddr_a), .dat_rdata_a(dat_rdata_a),
    .dat_raddr_b(dat_raddr_b), .dat_rdata_b(dat_rdata_b)
  );
endmodule

// File: tb/sim_dcache_wb.sv
module sim_dcache_wb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_sram_mode = 1'b0;
  logic        cpu_req_valid = 1'b0;
  logic        cpu_req_ready;
  logic        cpu_req_we = 1'b0;
  logic [31:0] cpu_req_addr = '0;
  logic [3:0]  cpu_req_be = '0;
  logic [31:0] cpu_req_wdata = '0;
  logic        cpu_rsp_valid;
  logic [31:0] cpu_rsp_rdata;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic        mem_req_we;
  logic [31:0] mem_req_addr;
  logic        mem_wvalid;
  logic        mem_wready = 1'b0;
  logic [31:0] mem_wdata;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #4 clk = ~clk; // 125 MHz

  dcache_wb u0 (.*);

  int n_chk = 0;
  int n_err = 0;

  logic [31:0] extm [4096];   // external memory model
  logic [31:0] refm [4096];   // architectural view in cache mode
  logic [31:0] sref [512];    // architectural view in SRAM mode
  logic [20:0] btag [128];
  bit          bval [128];
  bit          bdirty [128];

  int          n_req = 0;
  logic [31:0] log_addr [4];
  logic        log_we [4];

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw, input logic [3:0] be);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = nw[8*b +: 8];
    return r;
  endfunction

  // external burst memory model, decisions taken at the falling edge
  initial begin : mem_model
    int          mst = 0;
    int          mbeat = 0;
    logic [9:0]  mbase = '0;
    forever begin
      @(negedge clk);
      mem_req_ready = 1'b0;
      mem_wready    = 1'b0;
      mem_rvalid    = 1'b0;
      if (rst_n) begin
        case (mst)
          0: if (mem_req_valid && ($urandom % 3) != 0) begin
               mem_req_ready = 1'b1;
               if (n_req < 4) begin
                 log_addr[n_req] = mem_req_addr;
                 log_we[n_req]   = mem_req_we;
               end
               n_req++;
               mbase = mem_req_addr[13:4];
               mbeat = 0;
               mst   = mem_req_we ? 1 : 2;
             end
          1: begin
               if (mem_req_valid) chk(1'b0, "R6 request during write burst", 32'd1, 32'd0);
               if (mem_wvalid && ($urandom % 2) != 0) begin
                 mem_wready = 1'b1;
                 chk(mem_wdata === refm[{mbase, mbeat[1:0]}], "R6 write-back beat data",
                     mem_wdata, refm[{mbase, mbeat[1:0]}]);
                 extm[{mbase, mbeat[1:0]}] = mem_wdata;
                 mbeat++;
                 if (mbeat == 4) mst = 0;
               end
             end
          default: begin
               if (mem_req_valid) chk(1'b0, "R10 request during read burst", 32'd1, 32'd0);
               if (($urandom % 2) != 0) begin
                 mem_rvalid = 1'b1;
                 mem_rdata  = extm[{mbase, mbeat[1:0]}];
                 mbeat++;
                 if (mbeat == 4) mst = 0;
               end
             end
        endcase
      end
    end
  end

  // one processor access through the request stream
  task automatic do_op(input bit we, input logic [31:0] addr, input logic [3:0] be,
                       input logic [31:0] wd, output logic [31:0] rd, output int lat);
    @(negedge clk);
    cpu_req_valid = 1'b1;
    cpu_req_we    = we;
    cpu_req_addr  = addr;
    cpu_req_be    = be;
    cpu_req_wdata = wd;
    #1;
    while (!cpu_req_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    @(negedge clk);
    cpu_req_valid = 1'b0;
    lat = 1;
    while (!cpu_rsp_valid && lat < 300) begin
      if (cpu_req_ready) chk(1'b0, "R7 ready during miss", 32'd1, 32'd0);
      @(negedge clk);
      lat++;
    end
    rd = cpu_rsp_rdata;
  endtask

  task automatic cache_op(input bit we, input int widx, input logic [3:0] be, input logic [31:0] wd);
    logic [31:0] addr, rd, wb_addr, rf_addr;
    logic [6:0]  idx;
    logic [20:0] tag;
    bit          hit, dirty_miss;
    int          exp_n, lat;
    addr  = {18'd0, widx[11:0], 2'b00};
    idx   = addr[10:4];
    tag   = addr[31:11];
    hit   = bval[idx] && (btag[idx] == tag);
    dirty_miss = !hit && bval[idx] && bdirty[idx];
    exp_n = hit ? 0 : (dirty_miss ? 2 : 1);
    wb_addr = {btag[idx], idx, 4'b0};
    rf_addr = {addr[31:4], 4'b0};
    n_req = 0;
    do_op(we, addr, be, wd, rd, lat);
    chk(n_req == exp_n, "R5 burst request count", n_req, exp_n);
    if (hit) chk(lat == 1, "R2 hit latency", lat, 1);
    else     chk(lat > 1, "R7 miss stall", lat, 2);
    if (dirty_miss && n_req == 2) begin
      chk(log_we[0] == 1'b1 && log_addr[0] == wb_addr, "R6 write-back first at victim base", log_addr[0], wb_addr);
      chk(log_we[1] == 1'b0 && log_addr[1] == rf_addr, "R6 refill after write-back", log_addr[1], rf_addr);
    end else if (!hit && n_req == 1) begin
      chk(log_we[0] == 1'b0 && log_addr[0] == rf_addr, "R5 refill at line base", log_addr[0], rf_addr);
    end
    if (we) refm[widx] = merge(refm[widx], wd, be);
    else    chk(rd === refm[widx], "R2 load data", rd, refm[widx]);
    if (!hit) begin
      btag[idx] = tag;
      bval[idx] = 1'b1;
      bdirty[idx] = 1'b0;
    end
    if (we) bdirty[idx] = 1'b1;
  endtask

  task automatic sram_op(input bit we, input logic [31:0] addr, input logic [3:0] be, input logic [31:0] wd);
    logic [31:0] rd;
    int lat;
    n_req = 0;
    do_op(we, addr, be, wd, rd, lat);
    chk(lat == 1, "R8 SRAM latency", lat, 1);
    chk(n_req == 0, "R8 no bus traffic", n_req, 0);
    if (we) sref[addr[10:2]] = merge(sref[addr[10:2]], wd, be);
    else    chk(rd === sref[addr[10:2]], "R8 SRAM data", rd, sref[addr[10:2]]);
  endtask

  task automatic switch_mode(input bit m);
    @(negedge clk);
    cfg_sram_mode = m;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 128; i++) begin
      bval[i] = 1'b0;
      bdirty[i] = 1'b0;
    end
    for (int i = 0; i < 4096; i++) refm[i] = extm[i];
  endtask

  function automatic int pick_widx();
    if (($urandom % 2) == 0) return int'($urandom % 256);
    return int'($urandom % 4096);
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin : main
    logic [31:0] rd;
    int lat;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4096; i++) begin
      extm[i] = (i * 32'h9E3779B1) ^ 32'h5A5A_0F0F;
      refm[i] = extm[i];
    end
    for (int i = 0; i < 128; i++) begin
      bval[i] = 1'b0;
      bdirty[i] = 1'b0;
      btag[i] = '0;
    end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(cpu_req_ready == 1'b1, "R11 ready after reset", cpu_req_ready, 1);
    chk(cpu_rsp_valid == 1'b0, "R11 no response after reset", cpu_rsp_valid, 0);
    chk(mem_req_valid == 1'b0, "R11 no bus request after reset", mem_req_valid, 0);

    // directed: R11 first access misses, R3 store hit, R4 byte lanes, R1/R6 conflict eviction
    cache_op(1'b0, 12'h010, 4'hF, 32'h0);
    cache_op(1'b1, 12'h011, 4'b0101, 32'hAABB_CCDD);
    cache_op(1'b0, 12'h011, 4'hF, 32'h0);            // R4 merged lanes
    cache_op(1'b1, 12'h012, 4'b1000, 32'h1100_0000); // R3 hit store, no traffic
    cache_op(1'b0, 12'h210, 4'hF, 32'h0);            // R1 same index other tag, R6 dirty eviction
    cache_op(1'b0, 12'h011, 4'hF, 32'h0);            // written-back data returns, R6
    cache_op(1'b0, 12'h013, 4'hF, 32'h0);            // hit in refilled line

    // random cache traffic
    for (int k = 0; k < 1500; k++) begin
      int w = pick_widx();
      if (($urandom % 2) == 0) cache_op(1'b1, w, 4'($urandom % 16), $urandom);
      else                     cache_op(1'b0, w, 4'hF, 32'h0);
    end

    // R9 dirty data dropped by a mode switch
    cache_op(1'b1, 12'h345, 4'hF, 32'hDEAD_BEEF);
    switch_mode(1'b1);
    // R8 fill, then random with aliasing high address bits
    for (int i = 0; i < 512; i++) sram_op(1'b1, {21'd0, i[8:0], 2'b00}, 4'hF, $urandom);
    for (int k = 0; k < 400; k++) begin
      logic [31:0] a = $urandom & 32'hFFFF_FFFC;
      if (($urandom % 2) == 0) sram_op(1'b1, a, 4'($urandom % 16), $urandom);
      else                     sram_op(1'b0, a, 4'hF, 32'h0);
    end
    switch_mode(1'b0);
    n_req = 0;
    do_op(1'b0, {18'd0, 12'h345, 2'b00}, 4'hF, 32'h0, rd, lat);
    chk(n_req == 1 && log_we[0] == 1'b0, "R9 only a refill after switch", n_req, 1);
    chk(rd === extm[12'h345] && rd !== 32'hDEAD_BEEF, "R9 older memory value", rd, extm[12'h345]);
    bval[12'h345 >> 2 & 7'h7F] = 1'b1;
    btag[12'h345 >> 2 & 7'h7F] = 21'd0 | (12'h345 >> 9);

    for (int k = 0; k < 800; k++) begin
      int w = pick_widx();
      if (($urandom % 2) == 0) cache_op(1'b1, w, 4'($urandom % 16), $urandom);
      else                     cache_op(1'b0, w, 4'hF, 32'h0);
    end

    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule